// File: doc/BRIEF.md
# Rectangular Pixel Address Walker

This block turns a rectangle description into a stream of byte addresses, one per pixel, for a single image layer. The rectangle is given by a starting byte address, a width in pixels, a height in lines, a per-line skip count in pixels and a pixel format. Each address is offered with a valid/ready handshake. The same block serves as the read walker for a foreground or background layer or as the write walker for an output layer.

Geometry is captured when a start pulse arrives while the block is idle. The block then walks the rectangle line by line. For each address beat it also reports whether that pixel ends a line, ends the chosen watermark line, or is the final pixel of the whole rectangle. For 4-bit pixels, it reports which nibble of the addressed byte holds the pixel.

Configurations that cannot be walked are rejected at start. These are a start address not aligned to the pixel size, odd 4-bit geometry, an empty rectangle and an unknown format. A rejected start gives a one-cycle error pulse, and the block stays idle.

Top module: `rect_addr_gen`

## Requirements
- R1: After reset, `busy`, `addrValid` and `cfgErr` are all 0.
- R2: A `start` sampled while idle with a legal configuration sets `busy` and `addrValid` in the next cycle, with `addr` equal to `baseAddr` and `nibbleHi` equal to 0.
- R3: Format codes on `pixFmt` are 0 = 32-bit, 1 = 24-bit, 2 = 16-bit, 3 = 8-bit and 4 = 4-bit. Within a line, each accepted beat advances `addr` by 4, 3, 2 or 1 byte for codes 0 to 3.
- R4: For format 4, `nibbleHi` alternates 0,1 from the start of every line, and `addr` advances by one byte after each beat with `nibbleHi` equal to 1.
- R5: Pixel index p of line l (both from 0) sits at linear index l*(pixPerLine+lineSkip)+p. Its address is `baseAddr` plus the linear index times the pixel size. For format 4 the address is `baseAddr` plus half the linear index, with `nibbleHi` equal to the low bit of the index.
- R6: While `addrValid` is 1 and `addrReady` is 0, `addr`, `nibbleHi`, `lineEnd`, `wmHit` and `lastPix` hold their values.
- R7: `lineEnd` is 1 exactly on the beat carrying the last pixel of each line.
- R8: `wmHit` is 1 exactly on the last-pixel beat of the line whose index, counted from 0, equals `wmLine`. It never fires when `wmLine` is not below `numLines`.
- R9: `lastPix` is 1 on the final address beat. After that beat is accepted, `busy` and `addrValid` are 0 in the next cycle.
- R10: A start is rejected under any of these conditions: the format code is above 4; format 0 with `baseAddr[1:0]` nonzero; format 2 with `baseAddr[0]` set; format 4 with `pixPerLine` or `lineSkip` odd; `pixPerLine` or `numLines` zero. On rejection, `cfgErr` is 1 for exactly the next cycle and `busy` stays 0.
- R11: While busy, `start` and changes to every geometry and format input have no effect on the address stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| pixFmt | input | 3 | Pixel format code (see R3) |
| baseAddr | input | ADDR_W | Byte address of the first pixel |
| pixPerLine | input | PPL_W | Pixels in each line |
| numLines | input | LINE_W | Lines in the rectangle |
| lineSkip | input | LINE_W | Pixels skipped after each line |
| wmLine | input | LINE_W | Watermark line index, from 0 |
| addrReady | input | 1 | Consumer accepts the current address |
| addrValid | output | 1 | An address is offered |
| addr | output | ADDR_W | Byte address of the current pixel |
| nibbleHi | output | 1 | 4-bit format: pixel is in the high nibble |
| lineEnd | output | 1 | Current pixel ends its line |
| wmHit | output | 1 | Current pixel ends the watermark line |
| lastPix | output | 1 | Current pixel is the last of the rectangle |
| busy | output | 1 | A walk is in progress |
| cfgErr | output | 1 | One-cycle pulse for a rejected start |

## Verification
Suppose the pixel counter or line counter drifts. The next `lineEnd` then appears one beat early or late, and every address after it shifts by the line skip, so the error shows within one line. A wrong running address or nibble phase shows on the very next beat as an address that breaks the linear-index formula. For that reason every beat is compared, not just the line ends. A stall that is not honoured shows as a changed `addr` in the same stalled cycle. A lost or doubled skip shows at the first pixel of line 1.

// File: rtl/rag_pkg.sv
package rag_pkg;

  typedef enum logic [2:0] {
    PF_W32 = 3'd0,
    PF_W24 = 3'd1,
    PF_W16 = 3'd2,
    PF_W8  = 3'd3,
    PF_W4  = 3'd4
  } pixFmt_e;

  // strobes from the walk control to the address datapath
  typedef struct packed {
    logic load;     // accept a legal start: capture base and format
    logic advPix;   // step to the next pixel in the same line
    logic advLine;  // step from the last pixel of a line to the next line
  } ragStrobe_t;

endpackage

// File: rtl/rag_datapath.sv
module rag_datapath
  import rag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ragStrobe_t        strb,
  input  logic [2:0]        pixFmt,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SKIP_W-1:0] lineSkip,
  output logic              fmtBad,
  output logic              is4bit,
  output logic [ADDR_W-1:0] addr,
  output logic              nibbleHi
);

  logic [2:0]        sizeC;
  logic [ADDR_W-1:0] skipBytesC;
  logic              misalignC;
  logic              unknownC;

  pixFmt_e           fmtQ;
  logic [2:0]        sizeQ;
  logic [ADDR_W-1:0] skipBytesQ;
  logic [ADDR_W-1:0] curAddr;
  logic              nibQ;

  // decode the live format for the start check and the capture
  always_comb begin
    sizeC      = 3'd0;
    skipBytesC = '0;
    misalignC  = 1'b0;
    unknownC   = 1'b0;
    is4bit     = 1'b0;
    case (pixFmt_e'(pixFmt))
      PF_W32: begin
        sizeC      = 3'd4;
        skipBytesC = ADDR_W'(lineSkip) << 2;
        misalignC  = (baseAddr[1:0] != 2'b00);
      end
      PF_W24: begin
        sizeC      = 3'd3;
        skipBytesC = (ADDR_W'(lineSkip) << 1) + ADDR_W'(lineSkip);
      end
      PF_W16: begin
        sizeC      = 3'd2;
        skipBytesC = ADDR_W'(lineSkip) << 1;
        misalignC  = baseAddr[0];
      end
      PF_W8: begin
        sizeC      = 3'd1;
        skipBytesC = ADDR_W'(lineSkip);
      end
      PF_W4: begin
        is4bit     = 1'b1;
        skipBytesC = ADDR_W'(lineSkip) >> 1;
        misalignC  = lineSkip[0];
      end
      default: unknownC = 1'b1;
    endcase
  end

  assign fmtBad = misalignC | unknownC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtQ       <= PF_W32;
      sizeQ      <= 3'd0;
      skipBytesQ <= '0;
      curAddr    <= '0;
      nibQ       <= 1'b0;
    end else if (strb.load) begin
      fmtQ       <= pixFmt_e'(pixFmt);
      sizeQ      <= sizeC;
      skipBytesQ <= skipBytesC;
      curAddr    <= baseAddr;
      nibQ       <= 1'b0;
    end else if (strb.advPix) begin
      if (fmtQ == PF_W4) begin
        if (nibQ) curAddr <= curAddr + ADDR_W'(1);
        nibQ <= ~nibQ;
      end else begin
        curAddr <= curAddr + ADDR_W'(sizeQ);
      end
    end else if (strb.advLine) begin
      if (fmtQ == PF_W4) curAddr <= curAddr + ADDR_W'(1) + skipBytesQ;
      else               curAddr <= curAddr + ADDR_W'(sizeQ) + skipBytesQ;
      nibQ <= 1'b0;
    end
  end

  assign addr     = curAddr;
  assign nibbleHi = nibQ;

  // R4: even line width means every 4-bit line ends on a high nibble
  a_r4_line_ends_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advLine && fmtQ == PF_W4) |-> nibQ);

  // R6: control never issues two strobes in one cycle
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.advPix, strb.advLine}));

endmodule

// File: rtl/rag_ctrl.sv
module rag_ctrl
  import rag_pkg::*;
#(
  parameter int PPL_W  = 14,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PPL_W-1:0]  pixPerLine,
  input  logic [LINE_W-1:0] numLines,
  input  logic [LINE_W-1:0] wmLine,
  input  logic              is4bit,
  input  logic              fmtBad,
  input  logic              addrReady,
  output ragStrobe_t        strb,
  output logic              busy,
  output logic              cfgErr,
  output logic              lineEnd,
  output logic              wmHit,
  output logic              lastPix
);

  logic              runQ;
  logic              cfgErrQ;
  logic [PPL_W-1:0]  pplQ;
  logic [LINE_W-1:0] nlQ;
  logic [LINE_W-1:0] wmQ;
  logic [PPL_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;

  logic accept, startBad, fire, lineEndC, lastC;

  assign startBad = fmtBad || (pixPerLine == '0) || (numLines == '0) ||
                    (is4bit && pixPerLine[0]);
  assign accept   = start && !runQ;
  assign fire     = runQ && addrReady;
  assign lineEndC = runQ && (pixCnt == pplQ - PPL_W'(1));
  assign lastC    = lineEndC && (lineCnt == nlQ - LINE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      cfgErrQ <= 1'b0;
      pplQ    <= '0;
      nlQ     <= '0;
      wmQ     <= '0;
      pixCnt  <= '0;
      lineCnt <= '0;
    end else begin
      cfgErrQ <= accept && startBad;
      if (accept && !startBad) begin
        runQ    <= 1'b1;
        pplQ    <= pixPerLine;
        nlQ     <= numLines;
        wmQ     <= wmLine;
        pixCnt  <= '0;
        lineCnt <= '0;
      end else if (fire) begin
        if (lastC) begin
          runQ <= 1'b0;
        end else if (lineEndC) begin
          pixCnt  <= '0;
          lineCnt <= lineCnt + LINE_W'(1);
        end else begin
          pixCnt <= pixCnt + PPL_W'(1);
        end
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept && !startBad;
    strb.advPix  = fire && !lineEndC;
    strb.advLine = fire && lineEndC && !lastC;
  end

  assign busy    = runQ;
  assign cfgErr  = cfgErrQ;
  assign lineEnd = lineEndC;
  assign lastPix = lastC;
  assign wmHit   = lineEndC && (lineCnt == wmQ);

  // R9: the final beat also ends its line
  a_r9_last_is_line_end: assert property (@(posedge clk) disable iff (!rstN)
    lastPix |-> lineEnd);

  // R9: an accepted final beat returns the walker to idle
  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (lastPix && addrReady) |=> !busy);

  // R10: a rejected start never leaves the walker running
  a_r10_err_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !busy);

  // R6: a stalled beat keeps the position counters
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !addrReady) |=> (busy && $stable(pixCnt) && $stable(lineCnt)));

  // R7: the pixel counter stays inside the line
  a_r7_pix_in_line: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (pixCnt < pplQ));

endmodule

// File: rtl/rect_addr_gen.sv
module rect_addr_gen
  import rag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PPL_W  = 14,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        pixFmt,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [PPL_W-1:0]  pixPerLine,
  input  logic [LINE_W-1:0] numLines,
  input  logic [LINE_W-1:0] lineSkip,
  input  logic [LINE_W-1:0] wmLine,
  input  logic              addrReady,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addr,
  output logic              nibbleHi,
  output logic              lineEnd,
  output logic              wmHit,
  output logic              lastPix,
  output logic              busy,
  output logic              cfgErr
);

  ragStrobe_t strb;
  logic       fmtBad, is4bit;

  rag_ctrl #(.PPL_W(PPL_W), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .pixPerLine(pixPerLine), .numLines(numLines), .wmLine(wmLine),
    .is4bit(is4bit), .fmtBad(fmtBad), .addrReady(addrReady),
    .strb(strb), .busy(busy), .cfgErr(cfgErr),
    .lineEnd(lineEnd), .wmHit(wmHit), .lastPix(lastPix)
  );

  rag_datapath #(.ADDR_W(ADDR_W), .SKIP_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixFmt(pixFmt),
    .baseAddr(baseAddr), .lineSkip(lineSkip),
    .fmtBad(fmtBad), .is4bit(is4bit),
    .addr(addr), .nibbleHi(nibbleHi)
  );

  assign addrValid = busy;

endmodule

// File: tb/rect_addr_gen_tb.sv
`timescale 1ns/1ps
module rect_addr_gen_tb;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [31:0] base;
    logic [13:0] ppl;
    logic [15:0] nl;
    logic [15:0] skip;
    logic [15:0] wm;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h0000_1000, 14'd3, 16'd2, 16'd2, 16'd0, 1'b0},
    '{3'd1, 32'h0000_2001, 14'd2, 16'd3, 16'd1, 16'd1, 1'b0},
    '{3'd2, 32'h0000_3002, 14'd4, 16'd2, 16'd0, 16'd5, 1'b0},
    '{3'd3, 32'h0000_4003, 14'd5, 16'd1, 16'd3, 16'd0, 1'b0},
    '{3'd4, 32'h0000_5000, 14'd4, 16'd3, 16'd2, 16'd2, 1'b0},
    '{3'd0, 32'h0000_1002, 14'd2, 16'd2, 16'd0, 16'd0, 1'b1},
    '{3'd2, 32'h0000_3001, 14'd2, 16'd2, 16'd0, 16'd0, 1'b1},
    '{3'd4, 32'h0000_5000, 14'd3, 16'd2, 16'd2, 16'd0, 1'b1},
    '{3'd4, 32'h0000_5000, 14'd4, 16'd2, 16'd1, 16'd0, 1'b1},
    '{3'd3, 32'h0000_4000, 14'd0, 16'd2, 16'd0, 16'd0, 1'b1},
    '{3'd5, 32'h0000_4000, 14'd2, 16'd2, 16'd0, 16'd0, 1'b1},
    '{3'd0, 32'h0000_0010, 14'd1, 16'd1, 16'd0, 16'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  pixFmt = '0;
  logic [31:0] baseAddr = '0;
  logic [13:0] pixPerLine = '0;
  logic [15:0] numLines = '0;
  logic [15:0] lineSkip = '0;
  logic [15:0] wmLine = '0;
  logic        addrReady = 1'b0;
  logic        addrValid, nibbleHi, lineEnd, wmHit, lastPix, busy, cfgErr;
  logic [31:0] addr;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  rect_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .pixFmt(pixFmt),
    .baseAddr(baseAddr), .pixPerLine(pixPerLine), .numLines(numLines),
    .lineSkip(lineSkip), .wmLine(wmLine), .addrReady(addrReady),
    .addrValid(addrValid), .addr(addr), .nibbleHi(nibbleHi),
    .lineEnd(lineEnd), .wmHit(wmHit), .lastPix(lastPix),
    .busy(busy), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expBeat(input vec_t v, input int l, input int p);
    int unsigned idx;
    int unsigned sz;
    logic [31:0] a;
    logic        nib;
    idx = l * (int'(v.ppl) + int'(v.skip)) + p;
    case (v.fmt)
      3'd0: sz = 4;
      3'd1: sz = 3;
      3'd2: sz = 2;
      default: sz = 1;
    endcase
    if (v.fmt == 3'd4) begin
      a   = v.base + 32'(idx / 2);
      nib = idx[0];
    end else begin
      a   = v.base + 32'(idx * sz);
      nib = 1'b0;
    end
    expBeat = {27'd0, 1'b1, a, nib,
               (p == int'(v.ppl) - 1),
               (p == int'(v.ppl) - 1) && (l == int'(v.wm)),
               (p == int'(v.ppl) - 1) && (l == int'(v.nl) - 1)};
  endfunction

  function automatic logic [63:0] actBeat();
    actBeat = {27'd0, addrValid, addr, nibbleHi, lineEnd, wmHit, lastPix};
  endfunction

  // stall = 1: every beat is first held off one cycle while start and
  // all configuration inputs are disturbed
  task automatic runVec(input vec_t v, input bit stall);
    logic [63:0] e;
    @(negedge clk);
    pixFmt = v.fmt; baseAddr = v.base; pixPerLine = v.ppl;
    numLines = v.nl; lineSkip = v.skip; wmLine = v.wm;
    start = 1'b1; addrReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.err) begin
      chk(cfgErr && !busy && !addrValid, "R10 reject pulse",
          {62'd0, cfgErr, busy}, 64'd2);
      @(negedge clk);
      chk(!cfgErr && !busy, "R10 pulse one cycle, stays idle",
          {62'd0, cfgErr, busy}, 64'd0);
      return;
    end
    for (int l = 0; l < int'(v.nl); l++) begin
      for (int p = 0; p < int'(v.ppl); p++) begin
        e = expBeat(v, l, p);
        if (stall) begin
          addrReady = 1'b0;
          start = 1'b1;
          baseAddr = ~v.base; pixFmt = 3'd3; pixPerLine = 14'd1;
          numLines = 16'd1; lineSkip = 16'd7; wmLine = 16'd0;
          @(negedge clk);
          start = 1'b0;
          chk(actBeat() == e, "R6 R11 stalled beat held", actBeat(), e);
          addrReady = 1'b1;
        end
        chk(actBeat() == e, "R2 R3 R4 R5 R7 R8 R9 beat", actBeat(), e);
        @(negedge clk);
      end
    end
    chk(!busy && !addrValid, "R9 idle after last",
        {62'd0, busy, addrValid}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !addrValid && !cfgErr, "R1 reset state",
        {61'd0, busy, addrValid, cfgErr}, 64'd0);

    // table walk with a free-flowing consumer
    for (int i = 0; i < NV; i++) runVec(VECS[i], 1'b0);

    // directed: stalls plus disturbed inputs (R6, R11) on 32-bit and 4-bit
    runVec(VECS[0], 1'b1);
    runVec(VECS[4], 1'b1);
    // directed: rejected start leaves a following legal start intact (R10)
    runVec(VECS[8], 1'b0);
    runVec(VECS[1], 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule